// File: doc/BRIEF.md
# Read Buffer Watermark Tracker

This block watches the stream of byte addresses that a serial-flash front end serves out of a circular read buffer. The buffer is split into two equal halves. From those addresses the block raises two sticky interrupt bits. The watermark bit tells firmware that reading has gone far enough into the current half to start refilling the other half. The flip bit tells firmware that reading has just crossed from one half into the other. The block also records the address of the final byte that each data-carrying transaction read outside the mailbox window. That value is carried safely into the host clock domain.

Each served byte arrives as a valid/ready beat. It carries its 32-bit address and a flag that marks it as inside the mailbox window. The block never applies back-pressure: `rd_ready` is high whenever the byte domain is out of reset, so every beat presented with `rd_valid` is consumed in that cycle. A one-cycle `txn_end` pulse closes a transaction. It may coincide with the last byte. The threshold and the write-1-to-clear bits are plain control inputs in the byte clock domain.

Top module: `rbw_tracker`

## Requirements
- R1: For a consumed byte at address A, the position is (A+1) modulo HALF, where HALF = BUF_BYTES/2 (1024 by default). The position is used for both events.
- R2: When the position is greater than or equal to a nonzero `rd_threshold`, `irq_wm` becomes 1 on the cycle after the byte.
- R3: A threshold of zero never sets `irq_wm`.
- R4: After the watermark has fired once, no further byte sets it until a flip has occurred. The flip re-arms it.
- R5: When the position is zero (A ends in HALF-1), `irq_flip` becomes 1 on the cycle after the byte, whatever the watermark state.
- R6: Bytes with `rd_in_mbx`=1 raise no events and never change the recorded last address.
- R7: On `txn_end`, the recorded last address becomes the address of the final non-mailbox byte of that transaction. This includes a byte consumed in the same cycle as `txn_end`.
- R8: A transaction that consumed no non-mailbox byte leaves the recorded last address unchanged.
- R9: `host_last_addr` takes the recorded value within 2 byte-clock cycles plus 4 host-clock cycles. It only ever changes from one complete recorded value to another.
- R10: Both interrupt bits stay set until a 1 is written to the matching clear input (`clr_wm`, `clr_flip`). The clear takes effect on the next cycle.
- R11: When an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R12: After reset, both interrupt bits, the watermark-fired state and `host_last_addr` are 0.
- R13: `rd_ready` is 0 in reset and 1 from the first byte-clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Byte-side clock |
| rst_s_n | input | 1 | Byte-side reset, active low |
| clk_h | input | 1 | Host clock |
| rst_h_n | input | 1 | Host-side reset, active low |
| rd_valid | input | 1 | A served byte is presented |
| rd_ready | output | 1 | Byte accepted (no back-pressure) |
| rd_addr | input | ADDR_W | Address of the served byte |
| rd_in_mbx | input | 1 | Byte lies inside the mailbox window |
| txn_end | input | 1 | Transaction-end pulse |
| rd_threshold | input | HALF_W | Watermark position, 0 disables it |
| clr_wm | input | 1 | Write-1 clear of the watermark bit |
| clr_flip | input | 1 | Write-1 clear of the flip bit |
| irq_wm | output | 1 | Sticky watermark interrupt |
| irq_flip | output | 1 | Sticky flip interrupt |
| host_last_addr | output | ADDR_W | Last read address in the host domain |

## Verification
The interrupt bits and `rd_ready` are registered once after the byte edge. The bench's behavioural model updates on the same byte-clock edge as the design, and the two are compared at every falling edge, so each event is checked in exactly the cycle it is due. The recorded last address has to pass through the handshake into the host domain. The bench therefore waits 2 byte cycles and 6 host cycles after each `txn_end` before it compares `host_last_addr`, which is past the 4-host-cycle bound in R9. Transactions are spaced so that no handshake is still in flight when the next check is made.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  typedef struct packed {
    logic wm;
    logic flip;
  } rbw_evt_t;
endpackage

// File: rtl/rbw_events.sv
module rbw_events #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] threshold,
  input  logic              clr_wm,
  input  logic              clr_flip,
  output rbw_pkg::rbw_evt_t irq
);
  logic [ADDR_W-1:0] nxt;
  logic [HALF_W-1:0] pos;
  logic              fired_q;
  rbw_pkg::rbw_evt_t hit, irq_q;

  assign nxt      = addr + ADDR_W'(1);
  assign pos      = nxt[HALF_W-1:0];
  assign hit.flip = beat && (pos == '0);
  assign hit.wm   = beat && (threshold != '0) && (pos >= threshold) && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      irq_q   <= '0;
    end else begin
      if (hit.wm)        fired_q <= 1'b1;
      else if (hit.flip) fired_q <= 1'b0;
      irq_q.wm   <= (irq_q.wm & ~clr_wm) | hit.wm;
      irq_q.flip <= (irq_q.flip & ~clr_flip) | hit.flip;
    end
  end

  assign irq = irq_q;

  AST_ZERO_THR_NO_WM: assert property (@(posedge clk) disable iff (!rst_n)
    (threshold == '0 && !irq_q.wm) |=> !irq_q.wm); // R3
  AST_FLIP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && addr[HALF_W-1:0] == '1) |=> irq_q.flip); // R5
  AST_WM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q.wm && !clr_wm) |=> irq_q.wm); // R10
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && addr[HALF_W-1:0] == '1 && clr_flip) |=> irq_q.flip); // R11
  AST_WM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !(beat && pos == '0)) |=> fired_q); // R4
endmodule

// File: rtl/rbw_last_capture.sv
module rbw_last_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [ADDR_W-1:0] addr,
  input  logic              txn_end,
  output logic [ADDR_W-1:0] last_addr
);
  logic [ADDR_W-1:0] pend_q, last_q;
  logic              pend_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      last_q   <= '0;
    end else begin
      if (beat) pend_q <= addr;
      if (txn_end) begin
        pend_v_q <= 1'b0;
        if (beat)          last_q <= addr;
        else if (pend_v_q) last_q <= pend_q;
      end else if (beat) begin
        pend_v_q <= 1'b1;
      end
    end
  end

  assign last_addr = last_q;

  AST_NO_DATA_KEEPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !beat && !pend_v_q) |=> $stable(last_q)); // R8
  AST_END_TAKES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && beat) |=> last_q == $past(addr)); // R7
endmodule

// File: rtl/rbw_word_cdc.sv
module rbw_word_cdc #(
  parameter int W     = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_src,
  input  logic         rst_src_n,
  input  logic [W-1:0] src_word,
  input  logic         clk_dst,
  input  logic         rst_dst_n,
  output logic [W-1:0] dst_word
);
  logic         req_q;
  logic [W-1:0] hold_q;
  logic [STAGES-1:0] ack_sync;
  logic [STAGES-1:0] req_sync;
  logic         seen_q;
  logic [W-1:0] out_q;
  logic         busy;

  assign busy = req_q != ack_sync[STAGES-1];

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) begin
      req_q    <= 1'b0;
      hold_q   <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[STAGES-2:0], seen_q};
      if (!busy && src_word != hold_q) begin
        hold_q <= src_word;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge clk_dst or negedge rst_dst_n) begin
    if (!rst_dst_n) begin
      req_sync <= '0;
      seen_q   <= 1'b0;
      out_q    <= '0;
    end else begin
      req_sync <= {req_sync[STAGES-2:0], req_q};
      seen_q   <= req_sync[STAGES-1];
      if (req_sync[STAGES-1] != seen_q) out_q <= hold_q;
    end
  end

  assign dst_word = out_q;

  AST_HOLD_STABLE_IN_FLIGHT: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    busy |=> $stable(hold_q)); // R9
  AST_OUT_ONLY_ON_REQ: assert property (@(posedge clk_dst) disable iff (!rst_dst_n)
    (req_sync[STAGES-1] == seen_q) |=> $stable(out_q)); // R9
endmodule

// File: rtl/rbw_tracker.sv
module rbw_tracker #(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 2048,
  parameter int SYNC      = 2,
  localparam int HALF_W   = $clog2(BUF_BYTES / 2)
) (
  input  logic              clk_s,
  input  logic              rst_s_n,
  input  logic              clk_h,
  input  logic              rst_h_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_in_mbx,
  input  logic              txn_end,
  input  logic [HALF_W-1:0] rd_threshold,
  input  logic              clr_wm,
  input  logic              clr_flip,
  output logic              irq_wm,
  output logic              irq_flip,
  output logic [ADDR_W-1:0] host_last_addr
);
  logic              ready_q;
  logic              beat;
  logic [ADDR_W-1:0] last_s;
  rbw_pkg::rbw_evt_t irq;

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) ready_q <= 1'b0;
    else          ready_q <= 1'b1;
  end
  assign rd_ready = ready_q;
  assign beat     = rd_valid && ready_q && !rd_in_mbx;

  rbw_events #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_events (
    .clk(clk_s), .rst_n(rst_s_n), .beat(beat), .addr(rd_addr),
    .threshold(rd_threshold), .clr_wm(clr_wm), .clr_flip(clr_flip), .irq(irq)
  );

  rbw_last_capture #(.ADDR_W(ADDR_W)) u_last (
    .clk(clk_s), .rst_n(rst_s_n), .beat(beat), .addr(rd_addr),
    .txn_end(txn_end), .last_addr(last_s)
  );

  rbw_word_cdc #(.W(ADDR_W), .STAGES(SYNC)) u_cdc (
    .clk_src(clk_s), .rst_src_n(rst_s_n), .src_word(last_s),
    .clk_dst(clk_h), .rst_dst_n(rst_h_n), .dst_word(host_last_addr)
  );

  assign irq_wm   = irq.wm;
  assign irq_flip = irq.flip;

  AST_MBX_NO_EVENT: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (rd_valid && rd_in_mbx && !irq.flip && !clr_flip) |=> !irq.flip); // R6
  AST_READY_AFTER_RESET: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    1'b1 |=> rd_ready); // R13
endmodule

// File: tb/rbw_tracker_bench.sv
module rbw_tracker_bench;
  localparam int HALF = 1024;
  logic clk_s = 0, clk_h = 0, rst_s_n = 0, rst_h_n = 0;
  logic rd_valid = 0, rd_in_mbx = 0, txn_end = 0, clr_wm = 0, clr_flip = 0;
  logic [31:0] rd_addr = 0;
  logic [9:0]  rd_threshold = 0;
  logic rd_ready, irq_wm, irq_flip;
  logic [31:0] host_last_addr;

  always #4 clk_s = ~clk_s;
  always #5 clk_h = ~clk_h;

  rbw_tracker u_rbw_tracker (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .clk_h(clk_h), .rst_h_n(rst_h_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_in_mbx(rd_in_mbx),
    .txn_end(txn_end), .rd_threshold(rd_threshold), .clr_wm(clr_wm), .clr_flip(clr_flip),
    .irq_wm(irq_wm), .irq_flip(irq_flip), .host_last_addr(host_last_addr)
  );

  int checks = 0, fails = 0;
  string tag = "R12";
  bit m_wm, m_flip, m_fired, m_pv, m_ready;
  longint m_pend, m_last;
  bit done = 0;

  // behavioural reference model, one update per byte-clock edge
  always @(posedge clk_s) begin
    if (!rst_s_n) begin
      m_wm = 0; m_flip = 0; m_fired = 0; m_pv = 0; m_ready = 0; m_pend = 0; m_last = 0;
    end else begin
      bit hit_w, hit_f, take;
      longint pos;
      take = rd_valid && m_ready && !rd_in_mbx;
      hit_w = 0; hit_f = 0;
      if (take) begin
        pos = (longint'(rd_addr) + 1) % HALF;
        hit_w = (rd_threshold != 0) && (pos >= rd_threshold) && !m_fired;
        hit_f = (pos == 0);
        if (hit_w) m_fired = 1;
        if (hit_f) m_fired = 0;
        m_pend = rd_addr; m_pv = 1;
      end
      m_wm   = (m_wm && !clr_wm) || hit_w;
      m_flip = (m_flip && !clr_flip) || hit_f;
      if (txn_end) begin
        if (m_pv) m_last = m_pend;
        m_pv = 0;
      end
      m_ready = 1;
    end
  end

  // compare outputs against the model at every falling edge
  always @(negedge clk_s) begin
    if (!done) begin
      checks++;
      if (irq_wm !== m_wm || irq_flip !== m_flip || rd_ready !== m_ready) begin
        fails++;
        $display("FAIL %s: wm/flip/ready actual %b%b%b expected %b%b%b",
                 tag, irq_wm, irq_flip, rd_ready, m_wm, m_flip, m_ready);
      end
    end
  end

  task automatic beat(input longint a, input bit mbx, input bit last, input bit cw, input bit cf);
    @(negedge clk_s);
    rd_valid = 1; rd_addr = 32'(a); rd_in_mbx = mbx; txn_end = last; clr_wm = cw; clr_flip = cf;
    @(negedge clk_s);
    rd_valid = 0; txn_end = 0; clr_wm = 0; clr_flip = 0; rd_in_mbx = 0;
  endtask

  task automatic burst(input longint a0, input int n);
    for (int i = 0; i < n; i++) beat(a0 + i, 0, i == n - 1, 0, 0);
  endtask

  task automatic pulse(input bit te, input bit cw, input bit cf);
    @(negedge clk_s);
    txn_end = te; clr_wm = cw; clr_flip = cf;
    @(negedge clk_s);
    txn_end = 0; clr_wm = 0; clr_flip = 0;
  endtask

  task automatic check_host(input longint exp, input string t);
    repeat (2) @(negedge clk_s);
    repeat (6) @(negedge clk_h);
    checks++;
    if (host_last_addr !== 32'(exp)) begin
      fails++;
      $display("FAIL %s: host_last_addr actual %h expected %h", t, host_last_addr, 32'(exp));
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_s);
    tag = "R12";
    check_host(0, "R12 host reset value");
    rst_s_n = 1; rst_h_n = 1;
    tag = "R13 ready"; repeat (2) @(negedge clk_s);
    tag = "R3 zero threshold";
    burst(0, 40);
    check_host(39, "R7 R9 last addr 39");
    tag = "R2 R4 watermark once";
    rd_threshold = 16;
    burst(40, 30);
    check_host(69, "R7 last addr 69");
    tag = "R10 clear wm";
    pulse(0, 1, 0);
    tag = "R1 R5 flip crossing";
    burst(70, 1000);
    tag = "R4 rearm after flip";
    burst(1070, 10);
    check_host(1079, "R9 last addr 1079");
    tag = "R10 clear both";
    pulse(0, 1, 1);
    tag = "R11 event beats clear";
    beat(2047, 0, 1, 1, 1);
    check_host(2047, "R7 same-cycle end byte");
    pulse(0, 1, 1);
    tag = "R6 mailbox ignored";
    beat(3071, 1, 0, 0, 0);
    beat(3070, 1, 1, 0, 0);
    check_host(2047, "R6 mailbox keeps last addr");
    tag = "R8 empty transaction";
    pulse(1, 0, 0);
    check_host(2047, "R8 no data keeps last addr");
    tag = "R7 end after data";
    beat(4000, 0, 0, 0, 0);
    beat(4001, 1, 0, 0, 0);
    pulse(1, 0, 0);
    check_host(4000, "R7 final non-mailbox byte");
    repeat (3) @(negedge clk_s);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule